// File: doc/BRIEF.md
# Two-Way Data Cache with Per-Access Page Policy

This block is a two-way set-associative data cache. It sits between the stage that produces physical addresses and main memory. Each request brings a word address, a read/write flag, write data and two page attribute bits. One attribute makes the access skip the cache. The other forces that single write to go through to memory. Two global inputs also apply. One switches all caching off. The other makes every write a write-through write.

A word address is split into three fields. The high bits are the tag, the middle bits select a set, and the low bits select a word within the line. Both ways of the selected set are compared at the same time. Read hits are answered from the line without touching memory. A miss that allocates picks a victim way. If the victim line is dirty, it is written back as a whole line before the new line is fetched into that way. After the fetch, the access completes as a hit.

The memory side moves either one word or one full line per request, with a request/acknowledge handshake. A flush input writes back every dirty line, clears all lines, and then pulses a done output.

Top module: `cache_2way_policy`

## Requirements
- R1: A read that hits returns the stored word with no memory transaction. The word address is split as tag = high bits, set = the next IDX_W bits, and word = the low OFF_W bits.
- R2: A cacheable read miss fetches the whole line with one line read. It then returns the requested word from that line.
- R3: If the chosen victim is valid and dirty, it is written back with one line write before the fill's line read.
- R4: Victim order within a set is as follows. An invalid way is chosen first, way 0 before way 1. Otherwise the way not used most recently is chosen, where a hit or a fill counts as a use.
- R5: A write-back write hit updates only the line and leaves it dirty, with no memory traffic.
- R6: A write hit uses write-through when req_wthru or global_wt is 1. In that case it updates the line and performs one word write to memory.
- R7: A write miss with write-through in force performs one word write and does not allocate a line.
- R8: A write miss in write-back mode allocates the line with a fill and then merges the write data into it.
- R9: With req_nocache = 1, the access is a single word read or write to memory. No line is allocated.
- R10: With cache_en = 0, every access behaves as in R9.
- R11: flush_req writes back each dirty line with one line write and invalidates every line. flush_done then pulses for one cycle.
- R12: After reset, resp_valid, flush_done and mem_req are 0 and req_ready is 1. resp_valid is a one-cycle pulse.
- R13: While mem_req is high and not yet acknowledged, mem_req, mem_addr, mem_we and mem_line hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Global cache enable |
| global_wt | input | 1 | Global write-through mode |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_ready | output | 1 | Block is idle and can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_nocache | input | 1 | Page attribute: bypass the cache |
| req_wthru | input | 1 | Page attribute: write-through for this access |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Read data, valid with resp_valid on reads |
| flush_req | input | 1 | Start a flush of the whole cache |
| flush_done | output | 1 | One-cycle pulse at the end of a flush |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_line | output | 1 | 1 = whole-line transfer, 0 = single word |
| mem_we | output | 1 | 1 = write to memory |
| mem_addr | output | ADDR_W | Word address; line aligned for line transfers |
| mem_wdata | output | DATA_W*WORDS | Write data; a word transfer uses the low word |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | DATA_W*WORDS | Read data; a word transfer uses the low word |

## Verification
The assertions assume the following about memory:
- mem_ack is a single-cycle pulse.
- mem_ack arrives only while mem_req is high.
- mem_ack never arrives in the same cycle a request first appears.

The bench's memory model raises mem_ack exactly one cycle after it sees an unacknowledged request and lowers it the next cycle. This keeps the handshake within those assumptions.

The assertions also assume that requests and flushes are offered only while req_ready is 1. The bench waits for req_ready before every request or flush, and holds each strobe for a single cycle.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LOOK  = 3'd1,
    S_WORD  = 3'd2,
    S_EVICT = 3'd3,
    S_FILL  = 3'd4,
    S_FLUSH = 3'd5
  } cstate_t;
endpackage

// File: rtl/cache_way_match.sv
module cache_way_match #(
  parameter int TAG_W = 5
) (
  input  logic             valid_i,
  input  logic [TAG_W-1:0] tag_stored_i,
  input  logic [TAG_W-1:0] tag_req_i,
  output logic             hit_o
);
  assign hit_o = valid_i && (tag_stored_i == tag_req_i);
endmodule

// File: rtl/cache_line_merge.sv
module cache_line_merge #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int LINE_W = DATA_W * WORDS
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LINE_W-1:0] line_o,
  output logic [DATA_W-1:0] word_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign line_o[w*DATA_W +: DATA_W] =
      (off_i == OFF_W'(w)) ? wdata_i : line_i[w*DATA_W +: DATA_W];
  end

  always_comb begin
    word_o = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (off_i == OFF_W'(w)) word_o = line_i[w*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/cache_2way_policy.sv
module cache_2way_policy
  import cache_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cache_en,
  input  logic                    global_wt,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic                    req_nocache,
  input  logic                    req_wthru,
  output logic                    resp_valid,
  output logic [DATA_W-1:0]       resp_rdata,
  input  logic                    flush_req,
  output logic                    flush_done,
  output logic                    mem_req,
  output logic                    mem_line,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W*WORDS-1:0] mem_wdata,
  input  logic                    mem_ack,
  input  logic [DATA_W*WORDS-1:0] mem_rdata
);
  localparam int WAYS   = 2;
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = DATA_W * WORDS;
  localparam int FL_W   = IDX_W + 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // line storage
  logic [LINE_W-1:0] data_q [WAYS][SETS];
  logic [TAG_W-1:0]  tag_q  [WAYS][SETS];
  logic [SETS-1:0]   valid_q [WAYS];
  logic [SETS-1:0]   dirty_q [WAYS];
  logic [SETS-1:0]   lru_q;

  // captured request
  cstate_t           state_q, state_d;
  logic              r_write, r_byp, r_wt, vic_q, vic_d;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata, rdata_q, rdata_val;
  logic [FL_W-1:0]   fidx_q, fidx_d;
  logic              resp_q, resp_d, fdone_q, fdone_d, cap, rdata_ld;

  // address fields
  logic [IDX_W-1:0] set_i, f_set;
  logic [TAG_W-1:0] tag_i;
  logic [OFF_W-1:0] off_i;
  logic             f_way;
  assign set_i = r_addr[OFF_W +: IDX_W];
  assign tag_i = r_addr[ADDR_W-1 -: TAG_W];
  assign off_i = r_addr[OFF_W-1:0];
  assign f_set = fidx_q[FL_W-1:1];
  assign f_way = fidx_q[0];

  // parallel tag compare
  logic [WAYS-1:0] hit_vec;
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cache_way_match #(.TAG_W(TAG_W)) u_match (
      .valid_i     (valid_q[w][set_i]),
      .tag_stored_i(tag_q[w][set_i]),
      .tag_req_i   (tag_i),
      .hit_o       (hit_vec[w])
    );
  end
  logic hit, hit_way, victim;
  assign hit     = |hit_vec;
  assign hit_way = hit_vec[1];
  assign victim  = !valid_q[0][set_i] ? 1'b0 :
                   !valid_q[1][set_i] ? 1'b1 : lru_q[set_i];

  logic [LINE_W-1:0] merged_line;
  logic [DATA_W-1:0] hit_word;
  cache_line_merge #(.DATA_W(DATA_W), .WORDS(WORDS)) u_merge (
    .line_i (data_q[hit_way][set_i]),
    .off_i  (off_i),
    .wdata_i(r_wdata),
    .line_o (merged_line),
    .word_o (hit_word)
  );

  // next-state and strobes
  logic              lw_en, lw_way, fill_en, dirty_set, fl_clr, lru_en, lru_val;
  logic [LINE_W-1:0] lw_data;
  logic              fl_step;

  always_comb begin
    state_d = state_q;  vic_d = vic_q;  fidx_d = fidx_q;
    cap = 1'b0;  resp_d = 1'b0;  fdone_d = 1'b0;
    rdata_ld = 1'b0;  rdata_val = hit_word;
    lw_en = 1'b0;  lw_way = hit_way;  lw_data = merged_line;
    fill_en = 1'b0;  dirty_set = 1'b0;  fl_clr = 1'b0;
    lru_en = 1'b0;  lru_val = 1'b0;  fl_step = 1'b0;
    mem_req = 1'b0;  mem_line = 1'b0;  mem_we = 1'b0;
    mem_addr = r_addr;  mem_wdata = '0;
    case (state_q)
      S_IDLE: begin
        if (flush_req) begin
          state_d = S_FLUSH;
          fidx_d  = '0;
        end else if (req_valid) begin
          cap     = 1'b1;
          state_d = S_LOOK;
        end
      end
      S_LOOK: begin
        if (r_byp) begin
          state_d = S_WORD;
        end else if (hit) begin
          lru_en  = 1'b1;
          lru_val = ~hit_way;
          if (!r_write) begin
            resp_d = 1'b1;  rdata_ld = 1'b1;  state_d = S_IDLE;
          end else begin
            lw_en = 1'b1;
            if (r_wt) state_d = S_WORD;
            else begin
              dirty_set = 1'b1;  resp_d = 1'b1;  state_d = S_IDLE;
            end
          end
        end else if (r_write && r_wt) begin
          state_d = S_WORD;
        end else begin
          vic_d   = victim;
          state_d = (valid_q[victim][set_i] && dirty_q[victim][set_i]) ? S_EVICT : S_FILL;
        end
      end
      S_WORD: begin
        mem_req = 1'b1;
        mem_we  = r_write;
        mem_wdata[DATA_W-1:0] = r_wdata;
        if (mem_ack) begin
          resp_d    = 1'b1;
          rdata_ld  = !r_write;
          rdata_val = mem_rdata[DATA_W-1:0];
          state_d   = S_IDLE;
        end
      end
      S_EVICT: begin
        mem_req   = 1'b1;  mem_line = 1'b1;  mem_we = 1'b1;
        mem_addr  = {tag_q[vic_q][set_i], set_i, {OFF_W{1'b0}}};
        mem_wdata = data_q[vic_q][set_i];
        if (mem_ack) state_d = S_FILL;
      end
      S_FILL: begin
        mem_req  = 1'b1;  mem_line = 1'b1;
        mem_addr = {tag_i, set_i, {OFF_W{1'b0}}};
        if (mem_ack) begin
          lw_en = 1'b1;  lw_way = vic_q;  lw_data = mem_rdata;  fill_en = 1'b1;
          lru_en = 1'b1;  lru_val = ~vic_q;
          state_d = S_LOOK;
        end
      end
      S_FLUSH: begin
        if (valid_q[f_way][f_set] && dirty_q[f_way][f_set]) begin
          mem_req   = 1'b1;  mem_line = 1'b1;  mem_we = 1'b1;
          mem_addr  = {tag_q[f_way][f_set], f_set, {OFF_W{1'b0}}};
          mem_wdata = data_q[f_way][f_set];
          fl_step   = mem_ack;
        end else begin
          fl_step = 1'b1;
        end
        if (fl_step) begin
          fl_clr = 1'b1;
          fidx_d = fidx_q + 1'b1;
          if (fidx_q == '1) begin
            fdone_d = 1'b1;
            state_d = S_IDLE;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= S_IDLE;  vic_q <= 1'b0;  fidx_q <= '0;
      resp_q <= 1'b0;  fdone_q <= 1'b0;  rdata_q <= '0;
      r_write <= 1'b0;  r_byp <= 1'b0;  r_wt <= 1'b0;
      r_addr <= '0;  r_wdata <= '0;
    end else begin
      state_q <= state_d;  vic_q <= vic_d;  fidx_q <= fidx_d;
      resp_q  <= resp_d;   fdone_q <= fdone_d;
      if (rdata_ld) rdata_q <= rdata_val;
      if (cap) begin
        r_write <= req_write;
        r_byp   <= req_nocache | ~cache_en;
        r_wt    <= req_wthru | global_wt;
        r_addr  <= req_addr;
        r_wdata <= req_wdata;
      end
    end
  end

  // line state bits
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      for (int w = 0; w < WAYS; w++) begin
        valid_q[w] <= '0;
        dirty_q[w] <= '0;
      end
      lru_q <= '0;
    end else begin
      if (fill_en) begin
        valid_q[lw_way][set_i] <= 1'b1;
        dirty_q[lw_way][set_i] <= 1'b0;
      end
      if (dirty_set) dirty_q[lw_way][set_i] <= 1'b1;
      if (fl_clr) begin
        valid_q[f_way][f_set] <= 1'b0;
        dirty_q[f_way][f_set] <= 1'b0;
      end
      if (lru_en) lru_q[set_i] <= lru_val;
    end
  end

  // data and tag arrays, no reset
  always_ff @(posedge clk) begin
    if (lw_en)   data_q[lw_way][set_i] <= lw_data;
    if (fill_en) tag_q[lw_way][set_i]  <= tag_i;
  end

  assign req_ready  = (state_q == S_IDLE) && !flush_req && rst_i;
  assign resp_valid = resp_q;
  assign resp_rdata = rdata_q;
  assign flush_done = fdone_q;

  // checks
  a_r1_single_hit: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == S_LOOK) |-> $onehot0(hit_vec));
  a_r2_fill_hits: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == S_LOOK && $past(state_q) == S_FILL) |-> hit);
  a_r6_wt_hit_writes: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == S_LOOK && !r_byp && hit && r_write && r_wt) |=> (mem_req && mem_we && !mem_line));
  a_r9_bypass_no_line: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q != S_IDLE && state_q != S_FLUSH && r_byp) |-> !mem_line);
  a_r11_flush_clear: assert property (@(posedge clk) disable iff (!rst_i)
    flush_done |-> (valid_q[0] == '0 && valid_q[1] == '0));
  a_r12_resp_pulse: assert property (@(posedge clk) disable iff (!rst_i)
    resp_valid |=> !resp_valid);
  a_r13_mem_hold: assert property (@(posedge clk) disable iff (!rst_i)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_line)));
endmodule

// File: tb/cache_2way_policy_bench.sv
`timescale 1ns/1ps
module cache_2way_policy_bench;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int WORDS  = 4;
  localparam int LINE_W = DATA_W * WORDS;
  localparam int MEMN   = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n, cache_en, global_wt;
  logic              req_valid, req_ready, req_write, req_nocache, req_wthru;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, resp_rdata;
  logic              resp_valid, flush_req, flush_done;
  logic              mem_req, mem_line, mem_we, mem_ack;
  logic [ADDR_W-1:0] mem_addr;
  logic [LINE_W-1:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  cache_2way_policy u_cache_2way_policy (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .global_wt(global_wt),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_nocache(req_nocache),
    .req_wthru(req_wthru), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .flush_req(flush_req), .flush_done(flush_done), .mem_req(mem_req),
    .mem_line(mem_line), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: ack one cycle after an unacknowledged request
  logic [DATA_W-1:0] mem [MEMN];
  int cnt_lr, cnt_lw, cnt_wr, cnt_ww;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMN; i++) mem[i] <= 32'hC0DE0000 | i;
      mem_ack <= 1'b0;  mem_rdata <= '0;
      cnt_lr <= 0;  cnt_lw <= 0;  cnt_wr <= 0;  cnt_ww <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_line) begin
          if (mem_we) begin
            for (int k = 0; k < WORDS; k++) mem[int'(mem_addr) + k] <= mem_wdata[k*DATA_W +: DATA_W];
            cnt_lw <= cnt_lw + 1;
          end else begin
            for (int k = 0; k < WORDS; k++) mem_rdata[k*DATA_W +: DATA_W] <= mem[int'(mem_addr) + k];
            cnt_lr <= cnt_lr + 1;
          end
        end else if (mem_we) begin
          mem[mem_addr] <= mem_wdata[DATA_W-1:0];
          cnt_ww <= cnt_ww + 1;
        end else begin
          mem_rdata <= '0;
          mem_rdata[DATA_W-1:0] <= mem[mem_addr];
          cnt_wr <= cnt_wr + 1;
        end
      end
    end
  end

  int checks = 0;
  int errors = 0;

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit nc, input bit wt,
                        input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        output logic [DATA_W-1:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;  req_write = wr;  req_nocache = nc;  req_wthru = wt;
    req_addr = a;  req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    rd = resp_rdata;
  endtask

  // vector table
  typedef struct packed {
    logic              wr, nc, wt;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       wdata, exp;
    logic [1:0]        dlr, dlw, dwr, dww;
    logic [3:0]        rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,10'h004,32'h0,        32'hC0DE0004,2'd1,2'd0,2'd0,2'd0,4'd2}, // R2 read miss fill
    '{1'b0,1'b0,1'b0,10'h005,32'h0,        32'hC0DE0005,2'd0,2'd0,2'd0,2'd0,4'd1}, // R1 read hit
    '{1'b1,1'b0,1'b0,10'h006,32'h11111111, 32'h0,       2'd0,2'd0,2'd0,2'd0,4'd5}, // R5 write-back hit
    '{1'b0,1'b0,1'b0,10'h006,32'h0,        32'h11111111,2'd0,2'd0,2'd0,2'd0,4'd5}, // R5 reads merged word
    '{1'b0,1'b0,1'b0,10'h024,32'h0,        32'hC0DE0024,2'd1,2'd0,2'd0,2'd0,4'd4}, // R4 invalid way 1 chosen
    '{1'b0,1'b0,1'b0,10'h044,32'h0,        32'hC0DE0044,2'd1,2'd1,2'd0,2'd0,4'd3}, // R3 dirty way 0 evicted
    '{1'b0,1'b0,1'b0,10'h006,32'h0,        32'h11111111,2'd1,2'd0,2'd0,2'd0,4'd4}, // R4 clean LRU way 1 replaced
    '{1'b1,1'b1,1'b0,10'h100,32'h22222222, 32'h0,       2'd0,2'd0,2'd0,2'd1,4'd9}, // R9 bypass write
    '{1'b0,1'b1,1'b0,10'h100,32'h0,        32'h22222222,2'd0,2'd0,2'd1,2'd0,4'd9}, // R9 bypass read
    '{1'b1,1'b0,1'b1,10'h005,32'h33333333, 32'h0,       2'd0,2'd0,2'd0,2'd1,4'd6}, // R6 attribute write-through hit
    '{1'b0,1'b0,1'b0,10'h005,32'h0,        32'h33333333,2'd0,2'd0,2'd0,2'd0,4'd6}, // R6 line also updated
    '{1'b1,1'b0,1'b1,10'h200,32'h44444444, 32'h0,       2'd0,2'd0,2'd0,2'd1,4'd7}, // R7 write-through miss
    '{1'b0,1'b0,1'b0,10'h200,32'h0,        32'h44444444,2'd1,2'd0,2'd0,2'd0,4'd7}, // R7 not allocated
    '{1'b1,1'b0,1'b0,10'h301,32'h55555555, 32'h0,       2'd1,2'd0,2'd0,2'd0,4'd8}, // R8 write-allocate
    '{1'b0,1'b0,1'b0,10'h301,32'h0,        32'h55555555,2'd0,2'd0,2'd0,2'd0,4'd8}, // R8 merged into line
    '{1'b0,1'b0,1'b0,10'h100,32'h0,        32'h22222222,2'd1,2'd0,2'd0,2'd0,4'd9}  // R9 bypass left no line
  };

  task automatic delta_check(input int rq, input string tag_s, input int lr0, input int lw0,
                             input int wr0, input int ww0, input int elr, input int elw,
                             input int ewr, input int eww);
    check(cnt_lr - lr0 == elr, rq, {tag_s, " line reads"},  cnt_lr - lr0, elr);
    check(cnt_lw - lw0 == elw, rq, {tag_s, " line writes"}, cnt_lw - lw0, elw);
    check(cnt_wr - wr0 == ewr, rq, {tag_s, " word reads"},  cnt_wr - wr0, ewr);
    check(cnt_ww - ww0 == eww, rq, {tag_s, " word writes"}, cnt_ww - ww0, eww);
  endtask

  initial begin
    logic [DATA_W-1:0] rd;
    int lr0, lw0, wr0, ww0;
    rst_n = 1'b0;  cache_en = 1'b1;  global_wt = 1'b0;
    req_valid = 1'b0;  req_write = 1'b0;  req_nocache = 1'b0;  req_wthru = 1'b0;
    req_addr = '0;  req_wdata = '0;  flush_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    check(resp_valid == 1'b0, 12, "resp_valid after reset", resp_valid, 0);
    check(flush_done == 1'b0, 12, "flush_done after reset", flush_done, 0);
    check(mem_req == 1'b0,    12, "mem_req after reset", mem_req, 0);
    check(req_ready == 1'b1,  12, "req_ready after reset", req_ready, 1);

    for (int v = 0; v < NV; v++) begin
      lr0 = cnt_lr;  lw0 = cnt_lw;  wr0 = cnt_wr;  ww0 = cnt_ww;
      access(TBL[v].wr, TBL[v].nc, TBL[v].wt, TBL[v].addr, TBL[v].wdata, rd);
      @(negedge clk);
      check(resp_valid == 1'b0, 12, $sformatf("vec %0d response pulse width", v), resp_valid, 0);
      if (!TBL[v].wr)
        check(rd == TBL[v].exp, int'(TBL[v].rq), $sformatf("vec %0d read data", v), rd, TBL[v].exp);
      delta_check(int'(TBL[v].rq), $sformatf("vec %0d", v), lr0, lw0, wr0, ww0,
                  TBL[v].dlr, TBL[v].dlw, TBL[v].dwr, TBL[v].dww);
    end

    // R11 flush: one dirty line (0x300..0x303)
    lr0 = cnt_lr;  lw0 = cnt_lw;  wr0 = cnt_wr;  ww0 = cnt_ww;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    while (!flush_done) @(negedge clk);
    @(negedge clk);
    check(flush_done == 1'b0, 11, "flush_done pulse width", flush_done, 0);
    delta_check(11, "flush", lr0, lw0, wr0, ww0, 0, 1, 0, 0);
    access(1'b0, 1'b1, 1'b0, 10'h301, '0, rd);
    check(rd == 32'h55555555, 11, "flushed data in memory", rd, 32'h55555555);
    lr0 = cnt_lr;
    access(1'b0, 1'b0, 1'b0, 10'h301, '0, rd);
    check(cnt_lr - lr0 == 1, 11, "line invalid after flush", cnt_lr - lr0, 1);
    check(rd == 32'h55555555, 11, "refetched data", rd, 32'h55555555);

    // R6 global write-through on a hit
    global_wt = 1'b1;
    ww0 = cnt_ww;  lr0 = cnt_lr;
    access(1'b1, 1'b0, 1'b0, 10'h301, 32'h66666666, rd);
    check(cnt_ww - ww0 == 1, 6, "global write-through word write", cnt_ww - ww0, 1);
    check(cnt_lr - lr0 == 0, 6, "global write-through hit no fill", cnt_lr - lr0, 0);
    global_wt = 1'b0;
    access(1'b0, 1'b1, 1'b0, 10'h301, '0, rd);
    check(rd == 32'h66666666, 6, "memory holds write-through data", rd, 32'h66666666);
    access(1'b0, 1'b0, 1'b0, 10'h301, '0, rd);
    check(rd == 32'h66666666, 6, "line holds write-through data", rd, 32'h66666666);

    // R10 global disable
    cache_en = 1'b0;
    lr0 = cnt_lr;  wr0 = cnt_wr;
    access(1'b0, 1'b0, 1'b0, 10'h006, '0, rd);
    check(cnt_wr - wr0 == 1, 10, "disabled read uses word read", cnt_wr - wr0, 1);
    check(cnt_lr - lr0 == 0, 10, "disabled read no fill", cnt_lr - lr0, 0);
    check(rd == 32'h11111111, 10, "disabled read data", rd, 32'h11111111);
    cache_en = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule